// File: doc/BRIEF.md
# Bus Comparator Trigger Sequencer

This block sits beside a CPU bus and decides when a debug trigger fires and when a breakpoint is requested. Two programmable comparators, A and B, look at every valid bus cycle. Comparator A always looks at the address. Comparator B looks at either the address or the data of the same cycle, depending on the arrangement input. A mode input picks one of nine ways of combining the two results: single matches, an OR, an AND, a negated data match, an ordered pair, an inclusive address window and its complement, and two event-only modes. In the event-only modes every qualifying B match asks for the bus data to be stored, and no trigger is produced.

The engine is armed by a one-cycle strobe. It fires at most once per arming and then disarms itself. A breakpoint is an optional follow-on to a trigger. In tag form it is requested when the matched instruction address reaches the start of execution. In force form it is requested at the first instruction boundary after the match. The request carries the action to take: enter background debug, or execute a software interrupt.

Register access, trace storage and the CPU are outside this block. Configuration arrives on plain input pins.

Top module: `dbgtrig_top`

## Requirements
- R1: Comparator A compares `cmp_a` with `bus_addr`. Comparator B compares `cmp_b` with `bus_data` when `full_mode`=1, and with `bus_addr` when `full_mode`=0. A comparator matches only in a cycle with `bus_valid`=1.
- R2: The combining modes are `trig_mode`=0 (A), 1 (A or B), 3 (A and B) and 4 (A and not B). For each of them, a valid cycle that satisfies the mode raises the trigger.
- R3: In mode 2 (A then B), a B match raises the trigger only if an A match occurred in an earlier valid cycle of the same arming. An A match and a B match in the same cycle do not trigger.
- R4: Mode 7 (inside) triggers on a valid cycle with `cmp_a` <= `bus_addr` <= `cmp_b`, bounds included. Mode 8 (outside) triggers on any valid cycle that mode 7 would not trigger on.
- R5: In mode 5 (event B) every B match, and in mode 6 (A then event B) every B match after an earlier A match, pulses `store_req` with `store_data` equal to that cycle's `bus_data`. Neither mode ever pulses `trig_pulse`.
- R6: After `trig_pulse`, no further trigger occurs until a new `arm` strobe. An `arm` strobe clears all sequence state, including an A match already seen.
- R7: While the engine is disarmed (after reset, after `disarm`, after a trigger), `trig_pulse` and `store_req` stay low. Bus cycles in the same clock as `arm` or `disarm` are ignored.
- R8: With `brk_en`=1 and `brk_tag`=0, `brk_req` is high in the first cycle after the trigger's bus cycle in which `insn_bound`=1, and only in that cycle.
- R9: With `brk_en`=1 and `brk_tag`=1, `brk_req` is high in the first later cycle with `exec_start`=1 and `exec_addr` equal to the address of the bus cycle that triggered, and only in that cycle.
- R10: `brk_act` is 1 (software interrupt) when `brk_swi` was 1 at the trigger, and 0 (background debug) otherwise. With `brk_en`=0 a trigger never produces `brk_req`.
- R11: After reset all outputs are 0 and the engine is disarmed.
- R12: The mode codes 9 to 15 never trigger and never store.
- R13: `trig_pulse` and `store_req` are high for exactly the one cycle after the clock edge that samples the qualifying bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle strobe that arms the engine and clears its state |
| disarm | input | 1 | One-cycle strobe that disarms the engine; wins over `arm` |
| bus_valid | input | 1 | The bus carries a cycle this clock |
| bus_addr | input | BUS_W | Bus address |
| bus_data | input | BUS_W | Bus data |
| cmp_a | input | BUS_W | Comparator A reference (lower bound in range modes) |
| cmp_b | input | BUS_W | Comparator B reference (upper bound in range modes) |
| full_mode | input | 1 | 0: B compares the address; 1: B compares the data |
| trig_mode | input | 4 | Trigger mode code 0 to 8 |
| brk_en | input | 1 | A trigger also raises a breakpoint |
| brk_tag | input | 1 | 1: tag breakpoint; 0: force breakpoint |
| brk_swi | input | 1 | 1: software-interrupt action; 0: debug-mode action |
| insn_bound | input | 1 | The CPU is at an instruction boundary |
| exec_start | input | 1 | An instruction begins execution this cycle |
| exec_addr | input | BUS_W | Address of the instruction beginning execution |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| store_req | output | 1 | One-cycle data-store request (event modes) |
| store_data | output | BUS_W | Data to be stored |
| brk_req | output | 1 | Breakpoint request |
| brk_act | output | 1 | Action for `brk_req`: 1 software interrupt, 0 debug |

## Verification
The assertions take for granted that `cmp_a`, `cmp_b`, `full_mode`, `trig_mode` and the three breakpoint controls are held steady from an `arm` strobe until the trigger. They also assume that `arm` and `disarm` last one cycle and that the break inputs follow the CPU's real sequencing. The stimulus changes configuration only in the cycle that carries `arm`, and it drives every input half a cycle away from the sampling edge. Each table vector starts from a fresh arm, so no sequence state leaks between vectors.

// File: rtl/dbgtrig_pkg.sv
package dbgtrig_pkg;

    // Trigger mode codes; values above TM_OUTSIDE are reserved and inert.
    localparam logic [3:0] TM_A            = 4'd0;
    localparam logic [3:0] TM_A_OR_B       = 4'd1;
    localparam logic [3:0] TM_A_THEN_B     = 4'd2;
    localparam logic [3:0] TM_A_AND_B      = 4'd3;
    localparam logic [3:0] TM_A_NOT_B      = 4'd4;
    localparam logic [3:0] TM_EVT_B        = 4'd5;
    localparam logic [3:0] TM_A_THEN_EVT_B = 4'd6;
    localparam logic [3:0] TM_INSIDE       = 4'd7;
    localparam logic [3:0] TM_OUTSIDE      = 4'd8;

    localparam int NUM_CMP = 2;
    localparam int CMP_A   = 0;
    localparam int CMP_B   = 1;

    typedef enum logic {
        BRK_FORCE = 1'b0,
        BRK_TAG   = 1'b1
    } brk_kind_e;

    typedef enum logic {
        ACT_DEBUG = 1'b0,
        ACT_SWI   = 1'b1
    } brk_act_e;

    // Per-cycle comparator results.
    typedef struct packed {
        logic valid;
        logic a_hit;
        logic b_hit;
        logic in_win;
    } hit_t;

    // Decision of the mode decoder for one cycle.
    typedef struct packed {
        logic fire;
        logic store;
        logic mark_a;
    } step_t;

    function automatic logic is_ordered(input logic [3:0] mode);
        return (mode == TM_A_THEN_B) || (mode == TM_A_THEN_EVT_B);
    endfunction

    function automatic logic in_window(input logic [15:0] lo,
                                       input logic [15:0] hi,
                                       input logic [15:0] v);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/dbgtrig_cmp.sv
module dbgtrig_cmp #(
    parameter int W = 16
) (
    input  logic         valid,
    input  logic [W-1:0] operand,
    input  logic [W-1:0] ref_val,
    output logic         hit
);
    always_comb hit = valid && (operand == ref_val);
endmodule

// File: rtl/dbgtrig_eval.sv
module dbgtrig_eval
    import dbgtrig_pkg::*;
(
    input  logic [3:0] mode,
    input  hit_t       hits,
    input  logic       a_seen,
    output step_t      step
);
    always_comb begin
        step = '0;
        case (mode)
            TM_A:        step.fire = hits.a_hit;
            TM_A_OR_B:   step.fire = hits.a_hit || hits.b_hit;
            TM_A_THEN_B: begin
                step.fire   = hits.b_hit && a_seen;
                step.mark_a = hits.a_hit;
            end
            TM_A_AND_B:  step.fire = hits.a_hit && hits.b_hit;
            TM_A_NOT_B:  step.fire = hits.a_hit && !hits.b_hit;
            TM_EVT_B:    step.store = hits.b_hit;
            TM_A_THEN_EVT_B: begin
                step.store  = hits.b_hit && a_seen;
                step.mark_a = hits.a_hit;
            end
            TM_INSIDE:   step.fire = hits.valid && hits.in_win;
            TM_OUTSIDE:  step.fire = hits.valid && !hits.in_win;
            default:     step = '0;
        endcase
        if (!is_ordered(mode)) step.mark_a = 1'b0;
    end
endmodule

// File: rtl/dbgtrig_seq.sv
module dbgtrig_seq
    import dbgtrig_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm,
    input  logic         disarm,
    input  logic         bus_valid,
    input  logic [W-1:0] bus_data,
    input  step_t        step,
    output logic         a_seen,
    output logic         fire_now,
    output logic         trig_pulse,
    output logic         store_req,
    output logic [W-1:0] store_data
);
    logic armed_q;
    logic seen_q;
    logic live;

    assign live     = armed_q && !arm && !disarm;
    assign fire_now = live && step.fire;
    assign a_seen   = seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q    <= 1'b0;
            seen_q     <= 1'b0;
            trig_pulse <= 1'b0;
            store_req  <= 1'b0;
            store_data <= '0;
        end else begin
            trig_pulse <= 1'b0;
            store_req  <= 1'b0;
            if (disarm) begin
                armed_q <= 1'b0;
                seen_q  <= 1'b0;
            end else if (arm) begin
                armed_q <= 1'b1;
                seen_q  <= 1'b0;
            end else if (armed_q) begin
                if (step.mark_a) seen_q <= 1'b1;
                if (step.store) begin
                    store_req  <= 1'b1;
                    store_data <= bus_data;
                end
                if (step.fire) begin
                    trig_pulse <= 1'b1;
                    armed_q    <= 1'b0;
                    seen_q     <= 1'b0;
                end
            end
        end
    end

    // R6: a trigger leaves the engine disarmed
    p_once_per_arm_r6: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> !armed_q);

    // R7: nothing is produced from a disarmed state
    p_quiet_disarmed_r7: assert property (@(posedge clk) disable iff (rst)
        !armed_q |=> (!trig_pulse && !store_req));

    // R5: store requests and triggers never coincide
    p_store_not_trig_r5: assert property (@(posedge clk) disable iff (rst)
        store_req |-> !trig_pulse);

    // R13: every output pulse follows a valid bus cycle
    p_pulse_after_valid_r13: assert property (@(posedge clk) disable iff (rst)
        (trig_pulse || store_req) |-> $past(bus_valid));

    // R13: the trigger is one cycle wide
    p_pulse_width_r13: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |=> !trig_pulse);
endmodule

// File: rtl/dbgtrig_brk.sv
module dbgtrig_brk
    import dbgtrig_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         fire_now,
    input  logic [W-1:0] fire_addr,
    input  logic         brk_en,
    input  logic         brk_tag,
    input  logic         brk_swi,
    input  logic         insn_bound,
    input  logic         exec_start,
    input  logic [W-1:0] exec_addr,
    output logic         brk_req,
    output logic         brk_act
);
    logic         pend_q;
    brk_kind_e    kind_q;
    brk_act_e     act_q;
    logic [W-1:0] tag_addr_q;
    logic         reached;

    always_comb begin
        if (kind_q == BRK_TAG) reached = exec_start && (exec_addr == tag_addr_q);
        else                   reached = insn_bound;
    end

    assign brk_req = pend_q && reached;
    assign brk_act = pend_q && (act_q == ACT_SWI);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            kind_q     <= BRK_FORCE;
            act_q      <= ACT_DEBUG;
            tag_addr_q <= '0;
        end else if (clear) begin
            pend_q <= 1'b0;
        end else if (fire_now && brk_en) begin
            pend_q     <= 1'b1;
            kind_q     <= brk_tag ? BRK_TAG : BRK_FORCE;
            act_q      <= brk_swi ? ACT_SWI : ACT_DEBUG;
            tag_addr_q <= fire_addr;
        end else if (brk_req) begin
            pend_q <= 1'b0;
        end
    end

    // R8: a breakpoint request is issued once per pending break
    p_brk_single_r8: assert property (@(posedge clk) disable iff (rst)
        brk_req |=> !brk_req);
endmodule

// File: rtl/dbgtrig_top.sv
module dbgtrig_top
    import dbgtrig_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             disarm,
    input  logic             bus_valid,
    input  logic [BUS_W-1:0] bus_addr,
    input  logic [BUS_W-1:0] bus_data,
    input  logic [BUS_W-1:0] cmp_a,
    input  logic [BUS_W-1:0] cmp_b,
    input  logic             full_mode,
    input  logic [3:0]       trig_mode,
    input  logic             brk_en,
    input  logic             brk_tag,
    input  logic             brk_swi,
    input  logic             insn_bound,
    input  logic             exec_start,
    input  logic [BUS_W-1:0] exec_addr,
    output logic             trig_pulse,
    output logic             store_req,
    output logic [BUS_W-1:0] store_data,
    output logic             brk_req,
    output logic             brk_act
);
    logic [BUS_W-1:0] operand [NUM_CMP];
    logic [BUS_W-1:0] refs    [NUM_CMP];
    logic [NUM_CMP-1:0] cmp_hit;
    hit_t  hits;
    step_t step;
    logic  a_seen;
    logic  fire_now;

    assign operand[CMP_A] = bus_addr;
    assign operand[CMP_B] = full_mode ? bus_data : bus_addr;
    assign refs[CMP_A]    = cmp_a;
    assign refs[CMP_B]    = cmp_b;

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        dbgtrig_cmp #(.W(BUS_W)) u_cmp (
            .valid   (bus_valid),
            .operand (operand[i]),
            .ref_val (refs[i]),
            .hit     (cmp_hit[i])
        );
    end

    always_comb begin
        hits.valid  = bus_valid;
        hits.a_hit  = cmp_hit[CMP_A];
        hits.b_hit  = cmp_hit[CMP_B];
        hits.in_win = (bus_addr >= cmp_a) && (bus_addr <= cmp_b);
    end

    dbgtrig_eval u_eval (
        .mode   (trig_mode),
        .hits   (hits),
        .a_seen (a_seen),
        .step   (step)
    );

    dbgtrig_seq #(.W(BUS_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm),
        .disarm     (disarm),
        .bus_valid  (bus_valid),
        .bus_data   (bus_data),
        .step       (step),
        .a_seen     (a_seen),
        .fire_now   (fire_now),
        .trig_pulse (trig_pulse),
        .store_req  (store_req),
        .store_data (store_data)
    );

    dbgtrig_brk #(.W(BUS_W)) u_brk (
        .clk        (clk),
        .rst        (rst),
        .clear      (arm || disarm),
        .fire_now   (fire_now),
        .fire_addr  (bus_addr),
        .brk_en     (brk_en),
        .brk_tag    (brk_tag),
        .brk_swi    (brk_swi),
        .insn_bound (insn_bound),
        .exec_start (exec_start),
        .exec_addr  (exec_addr),
        .brk_req    (brk_req),
        .brk_act    (brk_act)
    );

    // R12: reserved mode codes produce neither trigger nor store
    p_reserved_inert_r12: assert property (@(posedge clk) disable iff (rst)
        (trig_mode > TM_OUTSIDE) |=> (!trig_pulse && !store_req));
endmodule

// File: tb/tb_dbgtrig_top.sv
module tb_dbgtrig_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        arm = 0, disarm = 0, bus_valid = 0;
    logic [15:0] bus_addr = 0, bus_data = 0, cmp_a = 0, cmp_b = 0, exec_addr = 0;
    logic        full_mode = 0, brk_en = 0, brk_tag = 0, brk_swi = 0;
    logic        insn_bound = 0, exec_start = 0;
    logic [3:0]  trig_mode = 0;
    logic        trig_pulse, store_req, brk_req, brk_act;
    logic [15:0] store_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    dbgtrig_top dut (.*);

    typedef struct packed {
        logic [3:0]  mode;
        logic        full;
        logic [15:0] a;
        logic [15:0] b;
        logic        v1;
        logic [15:0] ad1;
        logic [15:0] d1;
        logic        v2;
        logic [15:0] ad2;
        logic [15:0] d2;
        logic [1:0]  et;   // {trig after cycle 1, trig after cycle 2}
        logic [1:0]  es;   // {store after cycle 1, store after cycle 2}
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 1'b0, 16'h1000, 16'h2000, 1'b1, 16'h1000, 16'h0000, 1'b1, 16'h3000, 16'h0000, 2'b10, 2'b00, 8'd2},  // R2
        '{4'd0, 1'b0, 16'h1000, 16'h2000, 1'b1, 16'h1001, 16'h0000, 1'b1, 16'h1000, 16'h0000, 2'b01, 2'b00, 8'd2},  // R2
        '{4'd1, 1'b0, 16'h1000, 16'h2000, 1'b1, 16'h2000, 16'h0000, 1'b1, 16'h3000, 16'h0000, 2'b10, 2'b00, 8'd2},  // R2
        '{4'd2, 1'b0, 16'h1000, 16'h2000, 1'b1, 16'h2000, 16'h0000, 1'b1, 16'h1000, 16'h0000, 2'b00, 2'b00, 8'd3},  // R3
        '{4'd2, 1'b0, 16'h1000, 16'h2000, 1'b1, 16'h1000, 16'h0000, 1'b1, 16'h2000, 16'h0000, 2'b01, 2'b00, 8'd3},  // R3
        '{4'd3, 1'b1, 16'h1000, 16'hBEEF, 1'b1, 16'h1000, 16'hBEEF, 1'b1, 16'h3000, 16'h0000, 2'b10, 2'b00, 8'd1},  // R1
        '{4'd3, 1'b1, 16'h1000, 16'hBEEF, 1'b1, 16'h1000, 16'h0000, 1'b1, 16'h2000, 16'hBEEF, 2'b00, 2'b00, 8'd2},  // R2
        '{4'd4, 1'b1, 16'h1000, 16'hBEEF, 1'b1, 16'h1000, 16'hBEEF, 1'b1, 16'h1000, 16'h1234, 2'b01, 2'b00, 8'd2},  // R2
        '{4'd3, 1'b0, 16'h1000, 16'h1000, 1'b1, 16'h1000, 16'h0000, 1'b1, 16'h3000, 16'h0000, 2'b10, 2'b00, 8'd1},  // R1
        '{4'd3, 1'b0, 16'h1000, 16'h2000, 1'b1, 16'h1000, 16'h2000, 1'b1, 16'h3000, 16'h0000, 2'b00, 2'b00, 8'd1},  // R1
        '{4'd7, 1'b0, 16'h1000, 16'h2000, 1'b1, 16'h0FFF, 16'h0000, 1'b1, 16'h2000, 16'h0000, 2'b01, 2'b00, 8'd4},  // R4
        '{4'd7, 1'b0, 16'h1000, 16'h2000, 1'b1, 16'h1000, 16'h0000, 1'b1, 16'h3000, 16'h0000, 2'b10, 2'b00, 8'd4},  // R4
        '{4'd8, 1'b0, 16'h1000, 16'h2000, 1'b1, 16'h2000, 16'h0000, 1'b1, 16'h2001, 16'h0000, 2'b01, 2'b00, 8'd4},  // R4
        '{4'd8, 1'b0, 16'h1000, 16'h2000, 1'b1, 16'h0FFF, 16'h0000, 1'b1, 16'h1500, 16'h0000, 2'b10, 2'b00, 8'd4},  // R4
        '{4'd5, 1'b1, 16'h1000, 16'hBEEF, 1'b1, 16'h0000, 16'hBEEF, 1'b1, 16'h0000, 16'hBEEF, 2'b00, 2'b11, 8'd5},  // R5
        '{4'd6, 1'b1, 16'h1000, 16'hBEEF, 1'b1, 16'h2000, 16'hBEEF, 1'b1, 16'h1000, 16'hBEEF, 2'b00, 2'b00, 8'd5},  // R5
        '{4'd6, 1'b1, 16'h1000, 16'hBEEF, 1'b1, 16'h1000, 16'h0000, 1'b1, 16'h3000, 16'hBEEF, 2'b00, 2'b01, 8'd5},  // R5
        '{4'd5, 1'b0, 16'h1000, 16'h2000, 1'b1, 16'h2000, 16'h0000, 1'b0, 16'h2000, 16'h0000, 2'b00, 2'b10, 8'd5},  // R5
        '{4'd9, 1'b0, 16'h1000, 16'h1000, 1'b1, 16'h1000, 16'h0000, 1'b1, 16'h1000, 16'h0000, 2'b00, 2'b00, 8'd12}, // R12
        '{4'd15,1'b0, 16'h0000, 16'hFFFF, 1'b1, 16'h1000, 16'h0000, 1'b1, 16'h0000, 16'h0000, 2'b00, 2'b00, 8'd12}, // R12
        '{4'd0, 1'b0, 16'h1000, 16'h2000, 1'b0, 16'h1000, 16'h0000, 1'b1, 16'h1000, 16'h0000, 2'b01, 2'b00, 8'd13}, // R13
        '{4'd8, 1'b0, 16'h1000, 16'h2000, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0000, 16'h0000, 2'b01, 2'b00, 8'd13}, // R13
        '{4'd0, 1'b0, 16'h1000, 16'h2000, 1'b1, 16'h1000, 16'h0000, 1'b1, 16'h1000, 16'h0000, 2'b10, 2'b00, 8'd6}   // R6
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    // Called at a negedge; pulses arm for one cycle, returns at the next negedge.
    task automatic do_arm();
        arm = 1'b1;
        bus_valid = 1'b0;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic drive(input logic v, input logic [15:0] ad, input logic [15:0] d);
        bus_valid = v;
        bus_addr  = ad;
        bus_data  = d;
    endtask

    initial begin
        logic t1, t2, s1, s2;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        #1;
        chk("R11 trig_pulse", trig_pulse, 0);
        chk("R11 store_req", store_req, 0);
        chk("R11 brk_req", brk_req, 0);
        chk("R11 brk_act", brk_act, 0);
        // R11: disarmed after reset, an A match does nothing
        @(negedge clk);
        trig_mode = 4'd0; cmp_a = 16'h1000;
        drive(1, 16'h1000, 0);
        @(negedge clk);
        chk("R11 no trigger before arm", trig_pulse, 0);
        drive(0, 0, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            trig_mode = VECS[i].mode;
            full_mode = VECS[i].full;
            cmp_a     = VECS[i].a;
            cmp_b     = VECS[i].b;
            do_arm();
            drive(VECS[i].v1, VECS[i].ad1, VECS[i].d1);
            @(negedge clk);
            t1 = trig_pulse; s1 = store_req;
            drive(VECS[i].v2, VECS[i].ad2, VECS[i].d2);
            @(negedge clk);
            t2 = trig_pulse; s2 = store_req;
            drive(0, 0, 0);
            chk($sformatf("R%0d vector %0d trigger", VECS[i].req, i), {t1, t2}, VECS[i].et);
            chk($sformatf("R%0d vector %0d store", VECS[i].req, i), {s1, s2}, VECS[i].es);
        end

        // R5: stored data value
        @(negedge clk);
        trig_mode = 4'd5; full_mode = 1'b1; cmp_b = 16'hCAFE;
        do_arm();
        drive(1, 16'h0042, 16'hCAFE);
        @(negedge clk);
        chk("R5 store_req", store_req, 1);
        chk("R5 store_data", store_data, 16'hCAFE);
        drive(0, 0, 0);

        // R7: disarm stops an ordered sequence
        @(negedge clk);
        trig_mode = 4'd2; full_mode = 1'b0; cmp_a = 16'h1000; cmp_b = 16'h2000;
        do_arm();
        drive(1, 16'h1000, 0);
        @(negedge clk);
        drive(0, 0, 0); disarm = 1'b1;
        @(negedge clk);
        disarm = 1'b0;
        drive(1, 16'h2000, 0);
        @(negedge clk);
        chk("R7 no trigger after disarm", trig_pulse, 0);
        drive(0, 0, 0);

        // R6: re-arm clears the A match already seen
        @(negedge clk);
        do_arm();
        drive(1, 16'h1000, 0);
        @(negedge clk);
        do_arm();
        drive(1, 16'h2000, 0);
        @(negedge clk);
        chk("R6 re-arm clears A seen", trig_pulse, 0);
        drive(1, 16'h1000, 0);
        @(negedge clk);
        drive(1, 16'h2000, 0);
        @(negedge clk);
        chk("R6 sequence after re-arm", trig_pulse, 1);
        drive(0, 0, 0);

        // R8 / R10: force breakpoint with software-interrupt action
        @(negedge clk);
        trig_mode = 4'd0; brk_en = 1; brk_tag = 0; brk_swi = 1;
        do_arm();
        drive(1, 16'h1000, 0); insn_bound = 1;
        #1 chk("R8 no break in match cycle", brk_req, 0);
        @(negedge clk);
        drive(0, 0, 0); insn_bound = 0;
        #1 chk("R8 waits for boundary", brk_req, 0);
        @(negedge clk);
        insn_bound = 1;
        #1 chk("R8 break at boundary", brk_req, 1);
        chk("R10 swi action", brk_act, 1);
        @(negedge clk);
        #1 chk("R8 break only once", brk_req, 0);
        insn_bound = 0;

        // R9 / R10: tag breakpoint with debug action
        @(negedge clk);
        brk_tag = 1; brk_swi = 0;
        do_arm();
        drive(1, 16'h1000, 0); exec_start = 1; exec_addr = 16'h1000;
        #1 chk("R9 no break in match cycle", brk_req, 0);
        @(negedge clk);
        drive(0, 0, 0); exec_addr = 16'h1002;
        #1 chk("R9 other address ignored", brk_req, 0);
        @(negedge clk);
        exec_start = 0; exec_addr = 16'h1000;
        #1 chk("R9 needs exec_start", brk_req, 0);
        @(negedge clk);
        exec_start = 1;
        #1 chk("R9 break at tagged address", brk_req, 1);
        chk("R10 debug action", brk_act, 0);
        @(negedge clk);
        #1 chk("R9 break only once", brk_req, 0);
        exec_start = 0;

        // R10: breakpoints disabled
        @(negedge clk);
        brk_en = 0; brk_tag = 0;
        do_arm();
        drive(1, 16'h1000, 0); insn_bound = 1;
        @(negedge clk);
        drive(0, 0, 0);
        chk("R10 trigger still fires", trig_pulse, 1);
        #1 chk("R10 no break when disabled", brk_req, 0);
        @(negedge clk);
        #1 chk("R10 no break later", brk_req, 0);
        insn_bound = 0;

        @(negedge clk);
        finish_run();
    end
endmodule